// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits on the receive byte stream of an Ethernet MAC and watches every frame for a wake-up pattern addressed to this station. The pattern is a synchronisation run of at least six bytes of FFh. It must be followed at once by sixteen back-to-back copies of the station's 48-bit address. Any number of other bytes may appear before the run and after the last copy. The frame ends as usual with its CRC. The block does not store or deliver the frame. When it finds the pattern in a frame that the CRC checker marks good, it sets a sticky wake status bit and pulses a wake interrupt for one cycle.

The stream input is valid/ready. The block never applies back-pressure, so `s_ready` is held high and a byte is taken on every cycle in which `s_valid` is high. Cycles with `s_valid` low are idle gaps and do not disturb the search. Detection runs only while both receive enables are high. Software clears the status by strobing `clr_wr` with `clr_bit` set to one.

Top module: `mpkt_wake_top`

## Requirements
- R1: A frame holding six FFh bytes followed immediately by sixteen copies of `station_addr` sets the wake status. The copies are compared in transmission order, with `station_addr[47:40]` first and `station_addr[7:0]` last. Extra bytes before the run and after the last copy are allowed.
- R2: A detection is committed only on the beat that carries `s_eof`, and only if `frame_good` is high on that beat. `wake_sts` reads 1 from the cycle after that beat. A frame with `frame_good` low never sets `wake_sts`.
- R3: `wake_irq` is high for exactly one cycle, in the same cycle in which a detection commits to `wake_sts`.
- R4: `wake_sts` stays set until a cycle with `clr_wr`=1 and `clr_bit`=1, after which it reads 0. A write with `clr_bit`=0 has no effect.
- R5: If a commit and a clearing write fall on the same cycle, `wake_sts` ends up set.
- R6: A synchronisation run longer than six FFh bytes still qualifies, as long as the address copies follow the last FFh.
- R7: A mismatching byte during the address copies restarts the search. If that byte is FFh, it counts as the first byte of a new synchronisation run.
- R8: Fifteen copies, or sixteen copies sent in reversed byte order, do not set `wake_sts`.
- R9: Bytes are examined only while `rx_cmd_en` and `rx_mac_en` are both 1. A cycle with either enable at 0 resets the search, so a pattern interrupted by a disable is not detected.
- R10: The beat carrying `s_sof` restarts the search before it is examined, so a pattern cannot span two frames.
- R11: `s_ready` is always 1. Cycles with `s_valid` low between bytes do not break a pattern.
- R12: After reset, `wake_sts` and `wake_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_cmd_en | input | 1 | Command-level receive enable |
| rx_mac_en | input | 1 | MAC-level receive enable |
| s_valid | input | 1 | Receive byte valid |
| s_ready | output | 1 | Always 1; the block never stalls |
| s_data | input | 8 | Receive byte |
| s_sof | input | 1 | Marks the first byte of a frame |
| s_eof | input | 1 | Marks the last byte of a frame |
| frame_good | input | 1 | CRC verdict, sampled on the `s_eof` beat |
| station_addr | input | 48 | Station address, first-sent byte in bits 47:40 |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_bit | input | 1 | Write data for the clear bit |
| wake_sts | output | 1 | Sticky magic-packet wake status |
| wake_irq | output | 1 | One-cycle wake interrupt pulse |

## Verification
The bench targets the restart rules.

- **Mismatching FFh byte.** A copy is broken by an FFh byte and followed by only five more FFh bytes. A design that discards the mismatching byte misses this wake-up.
- **Seven-byte run.** A run of seven FFh bytes is sent. A design that counts the run exactly, instead of saturating, misses it.
- **Fifteen copies and reversed byte order.** These show whether the copy counter and the byte order are decoded correctly. A wrong design raises a false wake.

The bench also covers the commit rules:

- a bad CRC on a full pattern;
- a clearing write on the same cycle as a commit, where a design that lets the clear win loses the event;
- a disable in mid-frame and a new start of frame in mid-pattern, each of which a careless matcher would stitch into a false detection.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ADDR = 2'd1,
    ST_DONE = 2'd2
  } mstate_e;
endpackage

// File: rtl/mpw_byte_match.sv
module mpw_byte_match #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic [DATA_W-1:0]            data,
  input  logic [DATA_W*ADDR_BYTES-1:0] addr,
  input  logic [IDX_W-1:0]             idx,
  output logic                         is_ones,
  output logic                         hit_idx,
  output logic                         hit_first
);
  logic [ADDR_BYTES-1:0] eq;

  // byte 0 of the address is the first on the wire: the top slice
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_cmp
    assign eq[b] = (data == addr[(ADDR_BYTES-1-b)*DATA_W +: DATA_W]);
  end

  assign is_ones   = &data;
  assign hit_idx   = eq[idx];
  assign hit_first = eq[0];
endmodule

// File: rtl/mpw_seq.sv
module mpw_seq
  import mpw_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_BYTES = 6,
  parameter int REPEATS    = 16,
  localparam int IDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int RUN_W     = $clog2(SYNC_LEN + 1),
  localparam int CPY_W     = (REPEATS > 1) ? $clog2(REPEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  logic             frame_good,
  input  logic             is_ones,
  input  logic             hit_idx,
  input  logic             hit_first,
  output logic [IDX_W-1:0] idx,
  output logic             commit
);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(SYNC_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);
  localparam logic [CPY_W-1:0] CPY_LAST = CPY_W'(REPEATS - 1);

  mstate_e          state_q, cur_s, nxt_s;
  logic [RUN_W-1:0] run_q, cur_r, nxt_r;
  logic [IDX_W-1:0] idx_q, cur_i, nxt_i;
  logic [CPY_W-1:0] cpy_q, cur_c, nxt_c;

  always_comb begin
    cur_s = state_q;
    cur_r = run_q;
    cur_i = idx_q;
    cur_c = cpy_q;
    if (sof) begin
      cur_s = ST_HUNT;
      cur_r = '0;
      cur_i = '0;
      cur_c = '0;
    end
    nxt_s = cur_s;
    nxt_r = cur_r;
    nxt_i = cur_i;
    nxt_c = cur_c;
    unique case (cur_s)
      ST_HUNT: begin
        if (cur_r == RUN_MAX && hit_first) begin
          nxt_s = ST_ADDR;
          nxt_i = IDX_W'(1);
          nxt_c = '0;
        end else if (is_ones) begin
          nxt_r = (cur_r == RUN_MAX) ? cur_r : cur_r + 1'b1;
        end else begin
          nxt_r = '0;
        end
      end
      ST_ADDR: begin
        if (hit_idx) begin
          if (cur_i == IDX_LAST) begin
            nxt_i = '0;
            if (cur_c == CPY_LAST) nxt_s = ST_DONE;
            else nxt_c = cur_c + 1'b1;
          end else begin
            nxt_i = cur_i + 1'b1;
          end
        end else begin
          nxt_s = ST_HUNT;
          nxt_r = is_ones ? RUN_W'(1) : '0;
          nxt_i = '0;
          nxt_c = '0;
        end
      end
      default: ;
    endcase
  end

  assign idx    = idx_q;
  assign commit = beat && eof && frame_good && (nxt_s == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      run_q   <= '0;
      idx_q   <= '0;
      cpy_q   <= '0;
    end else if (!en || (beat && eof)) begin
      state_q <= ST_HUNT;
      run_q   <= '0;
      idx_q   <= '0;
      cpy_q   <= '0;
    end else if (beat) begin
      state_q <= nxt_s;
      run_q   <= nxt_r;
      idx_q   <= nxt_i;
      cpy_q   <= nxt_c;
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == ST_HUNT && run_q == '0)); // R9
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX); // R6
  AST_HUNT_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT) |-> (idx_q == '0 && cpy_q == '0)); // R7
endmodule

// File: rtl/mpw_status.sv
module mpw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_wr,
  input  logic clr_bit,
  output logic sts,
  output logic irq
);
  logic clr_hit;
  assign clr_hit = clr_wr & clr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= set;
      if (set) sts <= 1'b1;
      else if (clr_hit) sts <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> sts); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr_wr) |=> sts); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R3
endmodule

// File: rtl/mpkt_wake_top.sv
module mpkt_wake_top #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16,
  localparam int IDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_cmd_en,
  input  logic                         rx_mac_en,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [DATA_W-1:0]            s_data,
  input  logic                         s_sof,
  input  logic                         s_eof,
  input  logic                         frame_good,
  input  logic [DATA_W*ADDR_BYTES-1:0] station_addr,
  input  logic                         clr_wr,
  input  logic                         clr_bit,
  output logic                         wake_sts,
  output logic                         wake_irq
);
  logic             en, beat, is_ones, hit_idx, hit_first, commit;
  logic [IDX_W-1:0] idx;

  assign s_ready = 1'b1;
  assign en      = rx_cmd_en & rx_mac_en;
  assign beat    = s_valid & s_ready & en;

  mpw_byte_match #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES)) u_match (
    .data(s_data), .addr(station_addr), .idx(idx),
    .is_ones(is_ones), .hit_idx(hit_idx), .hit_first(hit_first)
  );

  mpw_seq #(.SYNC_LEN(SYNC_LEN), .ADDR_BYTES(ADDR_BYTES), .REPEATS(REPEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .beat(beat), .sof(s_sof), .eof(s_eof),
    .frame_good(frame_good), .is_ones(is_ones), .hit_idx(hit_idx),
    .hit_first(hit_first), .idx(idx), .commit(commit)
  );

  mpw_status u_sts (
    .clk(clk), .rst_n(rst_n), .set(commit), .clr_wr(clr_wr),
    .clr_bit(clr_bit), .sts(wake_sts), .irq(wake_irq)
  );

  AST_RISE_AT_GOOD_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_sts) |-> $past(s_valid && s_eof && frame_good && rx_cmd_en && rx_mac_en)); // R2
  AST_IRQ_WITH_STS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> wake_sts); // R3
endmodule

// File: tb/mpkt_wake_top_test.sv
module mpkt_wake_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_cmd_en = 1'b1, rx_mac_en = 1'b1;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, frame_good = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic [47:0] station_addr = 48'h11_22_33_44_55_66;
  logic        clr_wr = 1'b0, clr_bit = 1'b0;
  logic        s_ready, wake_sts, wake_irq;

  int checks = 0, errors = 0;
  logic [7:0] fbuf [0:255];
  int flen = 0;
  logic irq_seen;

  always #4 clk = ~clk;

  mpkt_wake_top uut (
    .clk(clk), .rst_n(rst_n), .rx_cmd_en(rx_cmd_en), .rx_mac_en(rx_mac_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof),
    .s_eof(s_eof), .frame_good(frame_good), .station_addr(station_addr),
    .clr_wr(clr_wr), .clr_bit(clr_bit), .wake_sts(wake_sts), .wake_irq(wake_irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_frame(); flen = 0; endtask
  task automatic add(input logic [7:0] b); fbuf[flen] = b; flen++; endtask
  task automatic add_ff(input int n); for (int i = 0; i < n; i++) add(8'hFF); endtask
  task automatic add_copies(input int n, input bit rev);
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 6; j++)
        add(rev ? station_addr[j*8 +: 8] : station_addr[(5-j)*8 +: 8]);
  endtask

  // drives bytes lo..hi-1 of the buffer; sof on byte 0, eof on the last byte
  task automatic play(input int lo, input int hi, input bit good, input bit gaps, input bit clr_last);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fbuf[i];
      s_sof = (i == 0); s_eof = (i == flen - 1);
      frame_good = (i == flen - 1) ? good : 1'b0;
      clr_wr = clr_last && (i == flen - 1); clr_bit = clr_wr;
      if (gaps) begin
        @(negedge clk);
        s_valid = 1'b0; clr_wr = 1'b0; clr_bit = 1'b0;
      end
    end
    @(negedge clk);
    irq_seen = wake_irq;
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; frame_good = 1'b0;
    clr_wr = 1'b0; clr_bit = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_wr = 1'b1; clr_bit = 1'b1;
    @(negedge clk); clr_wr = 1'b0; clr_bit = 1'b0;
  endtask

  task automatic magic_frame(input int ffn, input int copies, input bit rev);
    clr_frame(); add(8'h11); add(8'hA5); add(8'h00);
    add_ff(ffn); add_copies(copies, rev); add(8'h3C); add(8'hC3);
  endtask

  task automatic t_reset();
    check("R12", "wake_sts after reset", wake_sts, 0);
    check("R12", "wake_irq after reset", wake_irq, 0);
    check("R11", "s_ready", s_ready, 1);
  endtask

  task automatic t_basic();
    magic_frame(6, 16, 0); play(0, flen, 1, 0, 0);
    check("R1", "wake_sts after magic frame", wake_sts, 1);
    check("R3", "wake_irq on commit cycle", irq_seen, 1);
    @(negedge clk);
    check("R3", "wake_irq one cycle later", wake_irq, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); clr_wr = 1'b1; clr_bit = 1'b0;
    @(negedge clk); clr_wr = 1'b0;
    check("R4", "wake_sts after write of 0", wake_sts, 1);
    do_clear();
    check("R4", "wake_sts after write of 1", wake_sts, 0);
  endtask

  task automatic t_bad_crc();
    magic_frame(6, 16, 0); play(0, flen, 0, 0, 0);
    check("R2", "wake_sts with bad CRC", wake_sts, 0);
  endtask

  task automatic t_long_run();
    magic_frame(7, 16, 0); play(0, flen, 1, 0, 0);
    check("R6", "wake_sts with seven FFh", wake_sts, 1);
    do_clear();
  endtask

  task automatic t_restart();
    clr_frame(); add(8'h01); add_ff(6); add_copies(6, 0);
    add(8'h11); add(8'h22); add(8'hFF);
    add_ff(5); add_copies(16, 0); add(8'h77);
    play(0, flen, 1, 0, 0);
    check("R7", "FFh mismatch starts new run", wake_sts, 1);
    do_clear();
    clr_frame(); add_ff(6); add_copies(3, 0); add(8'h12);
    add_copies(13, 0); add(8'h77);
    play(0, flen, 1, 0, 0);
    check("R7", "mismatch breaks pattern", wake_sts, 0);
  endtask

  task automatic t_short_and_reversed();
    magic_frame(6, 15, 0); play(0, flen, 1, 0, 0);
    check("R8", "fifteen copies", wake_sts, 0);
    magic_frame(6, 16, 1); play(0, flen, 1, 0, 0);
    check("R8", "reversed byte order", wake_sts, 0);
  endtask

  task automatic t_disable();
    rx_mac_en = 1'b0;
    magic_frame(6, 16, 0); play(0, flen, 1, 0, 0);
    check("R9", "MAC enable low", wake_sts, 0);
    rx_mac_en = 1'b1; rx_cmd_en = 1'b0;
    play(0, flen, 1, 0, 0);
    check("R9", "command enable low", wake_sts, 0);
    rx_cmd_en = 1'b1;
    play(0, 50, 1, 0, 0);
    @(negedge clk); rx_mac_en = 1'b0;
    @(negedge clk); rx_mac_en = 1'b1;
    play(50, flen, 1, 0, 0);
    check("R9", "disable mid-frame", wake_sts, 0);
  endtask

  task automatic t_sof_restart();
    magic_frame(6, 16, 0);
    play(0, 60, 1, 0, 0);
    fbuf[0] = 8'h00;
    play(0, 1, 1, 0, 0);
    play(60, flen, 1, 0, 0);
    check("R10", "pattern split by new frame", wake_sts, 0);
  endtask

  task automatic t_gaps_and_set_wins();
    magic_frame(6, 16, 0); play(0, flen, 1, 1, 0);
    check("R11", "pattern with valid gaps", wake_sts, 1);
    play(0, flen, 1, 0, 1);
    check("R5", "set beats same-cycle clear", wake_sts, 1);
    check("R3", "irq on set-wins commit", irq_seen, 1);
    do_clear();
    check("R4", "clear afterwards", wake_sts, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_clear();
    t_bad_crc();
    t_long_run();
    t_restart();
    t_short_and_reversed();
    t_disable();
    t_sof_restart();
    t_gaps_and_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule